// File: doc/BRIEF.md
# Quadrature Encoder Up/Down Counter

This block is a timer counter with four selectable counting functions. In the clock function it counts up on ticks of a programmable prescaler driven by the internal clock. In the three encoder functions it counts up or down from a pair of quadrature inputs. It can count edges of input A only, edges of input B only, or edges of both inputs. Counting on both inputs gives four counts per quadrature cycle.

The count runs between zero and a programmable ceiling and wraps in both directions. Each wrap raises a one-cycle update pulse. A write to the ceiling can take effect at once, or it can be held in a buffer until the next update. The prescaler ratio is always held until the next update. A software update strobe forces an update: it clears the count, restarts the prescaler and loads the buffered values. A direct load port places any value in the count.

Both encoder inputs pass through a two-flop synchronizer. Edges are detected against the previous synchronized sample.

Top module: `qenc_counter`

## Requirements
- R1: After reset the count is 0, the direction bit is 0 and the update pulse is low. The active ceiling is the all-ones value and the prescaler ratio is 1, so in mode 0 a count loaded with all-ones minus one reaches all-ones and then wraps to 0.
- R2: With `cfg_mode` = 0 and `cfg_enable` = 1, the count advances by one every (ratio) clock cycles. The ratio is the prescaler field plus one. The encoder inputs have no effect in this mode, and the direction bit reads 0 after a tick.
- R3: While `cfg_enable` = 0 the count and the direction bit hold in every mode. An encoder edge that arrives while the block is disabled is discarded. The update strobe and the direct load still act.
- R4: With `cfg_mode` = 1 the count steps on each edge of A. It counts up when the new A level differs from B: A rising with B low counts up, A rising with B high counts down. Edges of B do nothing.
- R5: With `cfg_mode` = 2 the count steps on each edge of B. It counts up when the new B level equals A, so B falling with A low counts up. Edges of A do nothing.
- R6: With `cfg_mode` = 3 each edge of either input is one step. A edges follow the R4 rule and B edges follow the R5 rule. A change of both inputs in the same sampled cycle gives no step.
- R7: The direction bit is 1 after a down step and 0 after an up step. It holds when there is no step.
- R8: An up step from a value at or above the active ceiling gives 0. A down step from 0 gives the ceiling. Each wrap drives `update_o` high for one cycle, in the same cycle that the wrapped count appears.
- R9: With `cfg_arr_preload` = 0, a ceiling write governs the very next step. With preload = 1 the write waits in a buffer until the next update, from a wrap or from the strobe. A write in the same cycle as an update is taken by that update.
- R10: A prescaler write is held until the next update. An active ratio of 1 keeps counting every cycle until the wrap, and the new ratio applies after it.
- R11: `upd_gen` clears the count to 0, restarts the prescaler, loads the buffered ceiling and ratio, and pulses `update_o`. It overrides a step and a direct load in the same cycle.
- R12: `cnt_wr` puts `cnt_wdata` in the count on the next edge, even above the ceiling. It overrides a step in the same cycle and raises no update.
- R13: An encoder input change sampled at rising edge k shows in the count after edge k+2, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Counting enable |
| cfg_mode | input | 2 | Counting function: 0 clock, 1 A edges, 2 B edges, 3 both |
| cfg_arr_preload | input | 1 | Hold ceiling writes until the next update |
| arr_wr | input | 1 | Ceiling write strobe |
| arr_wdata | input | CNT_W | Ceiling value |
| psc_wr | input | 1 | Prescaler write strobe |
| psc_wdata | input | PSC_W | Prescaler ratio minus one |
| cnt_wr | input | 1 | Direct count load strobe |
| cnt_wdata | input | CNT_W | Count load value |
| upd_gen | input | 1 | Software update strobe |
| enc_a | input | 1 | Quadrature input A (asynchronous) |
| enc_b | input | 1 | Quadrature input B (asynchronous) |
| count_o | output | CNT_W | Current count |
| dir_o | output | 1 | 1 after a down step, 0 after an up step |
| update_o | output | 1 | One-cycle wrap or update pulse |

## Verification
The software update strobe can land in the same cycle as a prescaler tick that would have stepped the count, together with a preloaded ceiling write. The bench raises all three on one edge. It expects the count at 0, a single update pulse, and the newly written ceiling to set the following wrap point. The direct load is also made to meet a tick, and the bench expects the loaded value rather than a step. A wrap is made to coincide with a pending ceiling write, and the bench judges which ceiling is in force from the cycle of the next wrap.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

    typedef enum logic [1:0] {
        MODE_CLOCK  = 2'd0,
        MODE_ENC_A  = 2'd1,
        MODE_ENC_B  = 2'd2,
        MODE_ENC_AB = 2'd3
    } cnt_mode_e;

    // synchronized quadrature levels and their edge flags
    typedef struct packed {
        logic a_lvl;
        logic b_lvl;
        logic a_edge;
        logic b_edge;
    } quad_s;

    // one requested count movement
    typedef struct packed {
        logic step;
        logic down;
    } move_s;

    // an edge on A is backward when the new A level equals B
    function automatic logic a_edge_down(input quad_s q);
        return ~(q.a_lvl ^ q.b_lvl);
    endfunction

    // an edge on B is backward when the new B level differs from A
    function automatic logic b_edge_down(input quad_s q);
        return q.a_lvl ^ q.b_lvl;
    endfunction

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
    parameter int N_IN   = 2,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_IN-1:0] raw_i,
    output logic [N_IN-1:0] lvl_o,
    output logic [N_IN-1:0] edge_o
);

    for (genvar gi = 0; gi < N_IN; gi++) begin : g_chan
        logic [STAGES-1:0] pipe;
        logic              prev;

        always_ff @(posedge clk) begin
            if (rst) begin
                pipe <= '0;
                prev <= 1'b0;
            end else begin
                pipe <= {pipe[STAGES-2:0], raw_i[gi]};
                prev <= pipe[STAGES-1];
            end
        end

        assign lvl_o[gi]  = pipe[STAGES-1];
        assign edge_o[gi] = pipe[STAGES-1] ^ prev;
    end

endmodule

// File: rtl/qenc_prescaler.sv
module qenc_prescaler #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic             load_i,
    input  logic [PSC_W-1:0] ratio_m1_i,
    output logic             tick_o
);

    localparam logic [PSC_W-1:0] P_ONE = PSC_W'(1);

    logic [PSC_W-1:0] ratio_q;
    logic [PSC_W-1:0] div_q;

    assign tick_o = run_i && (div_q == ratio_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ratio_q <= '0;
            div_q   <= '0;
        end else begin
            if (load_i) begin
                ratio_q <= ratio_m1_i;
            end
            if (restart_i) begin
                div_q <= '0;
            end else if (run_i) begin
                div_q <= tick_o ? '0 : div_q + P_ONE;
            end
        end
    end

endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
    import qenc_pkg::*;
(
    input  cnt_mode_e mode_i,
    input  quad_s     quad_i,
    input  logic      tick_i,
    output move_s     move_o
);

    always_comb begin
        move_o = '0;
        unique case (mode_i)
            MODE_CLOCK: begin
                move_o.step = tick_i;
                move_o.down = 1'b0;
            end
            MODE_ENC_A: begin
                move_o.step = quad_i.a_edge;
                move_o.down = a_edge_down(quad_i);
            end
            MODE_ENC_B: begin
                move_o.step = quad_i.b_edge;
                move_o.down = b_edge_down(quad_i);
            end
            MODE_ENC_AB: begin
                // both inputs moving together is not a valid quadrature step
                move_o.step = quad_i.a_edge ^ quad_i.b_edge;
                move_o.down = quad_i.a_edge ? a_edge_down(quad_i)
                                            : b_edge_down(quad_i);
            end
            default: move_o = '0;
        endcase
    end

endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
    import qenc_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_enable,
    input  logic [1:0]       cfg_mode,
    input  logic             cfg_arr_preload,
    input  logic             arr_wr,
    input  logic [CNT_W-1:0] arr_wdata,
    input  logic             psc_wr,
    input  logic [PSC_W-1:0] psc_wdata,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             upd_gen,
    input  logic             enc_a,
    input  logic             enc_b,
    output logic [CNT_W-1:0] count_o,
    output logic             dir_o,
    output logic             update_o
);

    localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] C_MAX = {CNT_W{1'b1}};

    cnt_mode_e        mode;
    logic [1:0]       enc_lvl;
    logic [1:0]       enc_edge;
    quad_s            quad;
    logic             tick;
    move_s            move;
    logic             step_en;
    logic             wrap_up;
    logic             wrap_dn;
    logic             wrap;
    logic             update_now;
    logic [CNT_W-1:0] arr_buf_q;
    logic [CNT_W-1:0] arr_act_q;
    logic [PSC_W-1:0] psc_buf_q;
    logic [PSC_W-1:0] psc_load_val;
    logic [CNT_W-1:0] count_q;
    logic             dir_q;
    logic             update_q;

    assign mode = cnt_mode_e'(cfg_mode);

    qenc_sync #(
        .N_IN  (2),
        .STAGES(2)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .raw_i ({enc_a, enc_b}),
        .lvl_o (enc_lvl),
        .edge_o(enc_edge)
    );

    assign quad = '{a_lvl: enc_lvl[1], b_lvl: enc_lvl[0],
                    a_edge: enc_edge[1], b_edge: enc_edge[0]};

    qenc_prescaler #(
        .PSC_W(PSC_W)
    ) u_psc (
        .clk       (clk),
        .rst       (rst),
        .run_i     (cfg_enable && (mode == MODE_CLOCK)),
        .restart_i (update_now),
        .load_i    (update_now),
        .ratio_m1_i(psc_load_val),
        .tick_o    (tick)
    );

    qenc_decode u_dec (
        .mode_i(mode),
        .quad_i(quad),
        .tick_i(tick),
        .move_o(move)
    );

    // a step only counts when enabled and not displaced by a strobe
    assign step_en    = cfg_enable && move.step && !upd_gen && !cnt_wr;
    assign wrap_up    = step_en && !move.down && (count_q >= arr_act_q);
    assign wrap_dn    = step_en &&  move.down && (count_q == '0);
    assign wrap       = wrap_up || wrap_dn;
    assign update_now = upd_gen || wrap;

    // a write in the update cycle is taken by that update
    assign psc_load_val = psc_wr ? psc_wdata : psc_buf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            arr_buf_q <= C_MAX;
            arr_act_q <= C_MAX;
            psc_buf_q <= '0;
        end else begin
            if (arr_wr) begin
                arr_buf_q <= arr_wdata;
            end
            if (arr_wr && !cfg_arr_preload) begin
                arr_act_q <= arr_wdata;
            end else if (update_now) begin
                arr_act_q <= arr_wr ? arr_wdata : arr_buf_q;
            end
            if (psc_wr) begin
                psc_buf_q <= psc_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q  <= '0;
            dir_q    <= 1'b0;
            update_q <= 1'b0;
        end else begin
            update_q <= update_now;
            if (upd_gen) begin
                count_q <= '0;
            end else if (cnt_wr) begin
                count_q <= cnt_wdata;
            end else if (step_en) begin
                dir_q <= move.down;
                if (wrap_up) begin
                    count_q <= '0;
                end else if (wrap_dn) begin
                    count_q <= arr_act_q;
                end else if (move.down) begin
                    count_q <= count_q - C_ONE;
                end else begin
                    count_q <= count_q + C_ONE;
                end
            end
        end
    end

    assign count_o  = count_q;
    assign dir_o    = dir_q;
    assign update_o = update_q;

endmodule

// File: rtl/qenc_counter_chk.sv
module qenc_counter_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_enable,
    input logic [1:0]       cfg_mode,
    input logic             upd_gen,
    input logic             cnt_wr,
    input logic [CNT_W-1:0] cnt_wdata,
    input logic [CNT_W-1:0] count_o,
    input logic             dir_o,
    input logic             update_o
);

    localparam logic [CNT_W-1:0] K_ONE = CNT_W'(1);

    p_hold_disabled_r3: assert property (@(posedge clk) disable iff (rst)
        (!cfg_enable && !upd_gen && !cnt_wr) |=> ($stable(count_o) && !update_o));

    p_strobe_clears_r11: assert property (@(posedge clk) disable iff (rst)
        upd_gen |=> (count_o == '0 && update_o));

    p_direct_load_r12: assert property (@(posedge clk) disable iff (rst)
        (cnt_wr && !upd_gen) |=> (count_o == $past(cnt_wdata) && !update_o));

    p_up_wrap_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (update_o && !dir_o) |-> (count_o == '0));

    p_unit_step_r7: assert property (@(posedge clk) disable iff (rst)
        (!upd_gen && !cnt_wr) |=> (update_o || $stable(count_o)
            || (count_o == $past(count_o) + K_ONE && !dir_o)
            || (count_o == $past(count_o) - K_ONE && dir_o)));

    p_clock_mode_up_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == 2'd0 && !upd_gen && !cnt_wr) |=> (!dir_o || $stable(count_o)));

endmodule

bind qenc_counter qenc_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_enable(cfg_enable),
    .cfg_mode  (cfg_mode),
    .upd_gen   (upd_gen),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (cnt_wdata),
    .count_o   (count_o),
    .dir_o     (dir_o),
    .update_o  (update_o)
);

// File: tb/tb_qenc_counter.sv
`timescale 1ns/1ps
module tb_qenc_counter;

    localparam int CW = 16;
    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_enable = 1'b0;
    logic [1:0]    cfg_mode = 2'd0;
    logic          cfg_arr_preload = 1'b0;
    logic          arr_wr = 1'b0;
    logic [CW-1:0] arr_wdata = '0;
    logic          psc_wr = 1'b0;
    logic [PW-1:0] psc_wdata = '0;
    logic          cnt_wr = 1'b0;
    logic [CW-1:0] cnt_wdata = '0;
    logic          upd_gen = 1'b0;
    logic          enc_a = 1'b0;
    logic          enc_b = 1'b0;
    logic [CW-1:0] count_o;
    logic          dir_o;
    logic          update_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    qenc_counter dut (
        .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_mode(cfg_mode),
        .cfg_arr_preload(cfg_arr_preload), .arr_wr(arr_wr), .arr_wdata(arr_wdata),
        .psc_wr(psc_wr), .psc_wdata(psc_wdata), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .upd_gen(upd_gen), .enc_a(enc_a), .enc_b(enc_b),
        .count_o(count_o), .dir_o(dir_o), .update_o(update_o)
    );

    // vector fields: mode[8:7] a[6] b[5] count[4:1] dir[0]; ceiling is 9
    localparam int NV = 26;
    localparam logic [8:0] VEC [NV] = '{
        {2'd1, 1'b1, 1'b0, 4'd1, 1'b0},
        {2'd1, 1'b1, 1'b1, 4'd1, 1'b0},
        {2'd1, 1'b0, 1'b1, 4'd2, 1'b0},
        {2'd1, 1'b0, 1'b0, 4'd2, 1'b0},
        {2'd1, 1'b0, 1'b1, 4'd2, 1'b0},
        {2'd1, 1'b1, 1'b1, 4'd1, 1'b1},
        {2'd1, 1'b1, 1'b0, 4'd1, 1'b1},
        {2'd1, 1'b0, 1'b0, 4'd0, 1'b1},
        {2'd1, 1'b1, 1'b0, 4'd1, 1'b0},
        {2'd1, 1'b0, 1'b0, 4'd0, 1'b1},
        {2'd1, 1'b0, 1'b1, 4'd0, 1'b1},
        {2'd1, 1'b1, 1'b1, 4'd9, 1'b1},
        {2'd2, 1'b1, 1'b0, 4'd8, 1'b1},
        {2'd2, 1'b0, 1'b0, 4'd8, 1'b1},
        {2'd2, 1'b0, 1'b1, 4'd7, 1'b1},
        {2'd2, 1'b1, 1'b1, 4'd7, 1'b1},
        {2'd2, 1'b0, 1'b1, 4'd7, 1'b1},
        {2'd2, 1'b0, 1'b0, 4'd8, 1'b0},
        {2'd3, 1'b1, 1'b0, 4'd9, 1'b0},
        {2'd3, 1'b1, 1'b1, 4'd0, 1'b0},
        {2'd3, 1'b0, 1'b1, 4'd1, 1'b0},
        {2'd3, 1'b0, 1'b0, 4'd2, 1'b0},
        {2'd3, 1'b0, 1'b1, 4'd1, 1'b1},
        {2'd3, 1'b1, 1'b1, 4'd0, 1'b1},
        {2'd3, 1'b1, 1'b0, 4'd9, 1'b1},
        {2'd3, 1'b0, 1'b1, 4'd9, 1'b1}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        edges(3);
        rst = 1'b0;
        // R1 reset state
        check("R1", "count after reset", count_o, 0);
        check("R1", "dir after reset", dir_o, 0);
        check("R1", "update after reset", update_o, 0);

        // ceiling 9 taken at once, encoder mode 1
        arr_wr = 1'b1; arr_wdata = 16'd9; cfg_mode = 2'd1; cfg_enable = 1'b1;
        edges(1);
        arr_wr = 1'b0;

        for (int i = 0; i < NV; i++) begin
            cfg_mode = VEC[i][8:7];
            enc_a    = VEC[i][6];
            enc_b    = VEC[i][5];
            edges(4);
            check(VEC[i][8:7] == 2'd1 ? "R4" : (VEC[i][8:7] == 2'd2 ? "R5" : "R6"),
                  "vector count", count_o, 32'(VEC[i][4:1]));
            check("R7", "vector dir", dir_o, 32'(VEC[i][0]));
        end

        // R13 synchronizer latency, mode 3 from a0 b1: A rise is a down step
        enc_a = 1'b1;
        edges(2);
        check("R13", "count before latency", count_o, 9);
        edges(1);
        check("R13", "count after latency", count_o, 8);

        // R3 disabled encoder edge is lost
        cfg_enable = 1'b0;
        enc_a = 1'b0;
        edges(4);
        check("R3", "count while disabled", count_o, 8);
        check("R3", "dir while disabled", dir_o, 1);
        cfg_enable = 1'b1;
        edges(4);
        check("R3", "no late step", count_o, 8);

        // R2 clock mode with ratio 3, loaded by the strobe
        cfg_enable = 1'b0; cfg_mode = 2'd0; psc_wr = 1'b1; psc_wdata = 16'd2;
        edges(1);
        psc_wr = 1'b0; upd_gen = 1'b1;
        edges(1);
        check("R11", "strobe count", count_o, 0);
        check("R11", "strobe pulse", update_o, 1);
        upd_gen = 1'b0; cfg_enable = 1'b1;
        edges(7);
        enc_b = ~enc_b;
        edges(8);
        check("R2", "ratio 3 after 15 edges", count_o, 5);
        check("R2", "dir in clock mode", dir_o, 0);
        edges(14);
        check("R2", "count before wrap", count_o, 9);
        check("R8", "no pulse before wrap", update_o, 0);
        edges(1);
        check("R8", "up wrap count", count_o, 0);
        check("R8", "up wrap pulse", update_o, 1);
        edges(1);
        check("R8", "pulse one cycle", update_o, 0);

        // R9 preloaded ceiling held until the wrap
        cfg_enable = 1'b0; psc_wr = 1'b1; psc_wdata = 16'd0;
        edges(1);
        psc_wr = 1'b0; upd_gen = 1'b1;
        edges(1);
        upd_gen = 1'b0;
        check("R11", "strobe count again", count_o, 0);
        cfg_enable = 1'b1; cfg_arr_preload = 1'b1; arr_wr = 1'b1; arr_wdata = 16'd3;
        edges(1);
        arr_wr = 1'b0;
        edges(4);
        check("R9", "old ceiling still active", count_o, 5);
        edges(5);
        check("R9", "wrap at old ceiling", count_o, 0);
        check("R9", "wrap pulse old ceiling", update_o, 1);
        edges(3);
        check("R9", "count at new ceiling", count_o, 3);
        edges(1);
        check("R9", "wrap at new ceiling", count_o, 0);
        check("R9", "wrap pulse new ceiling", update_o, 1);

        // R11 strobe meets a tick and a preloaded ceiling write
        upd_gen = 1'b1; arr_wr = 1'b1; arr_wdata = 16'd5;
        edges(1);
        upd_gen = 1'b0; arr_wr = 1'b0;
        check("R11", "strobe beats tick", count_o, 0);
        check("R11", "strobe pulse with write", update_o, 1);
        edges(5);
        check("R9", "write taken by strobe", count_o, 5);
        edges(1);
        check("R9", "wrap at ceiling 5", count_o, 0);

        // R12 direct load beats a tick, above the ceiling
        cnt_wr = 1'b1; cnt_wdata = 16'd7;
        edges(1);
        cnt_wr = 1'b0;
        check("R12", "loaded count", count_o, 7);
        check("R12", "no pulse on load", update_o, 0);
        edges(1);
        check("R12", "wrap from above ceiling", count_o, 0);
        check("R8", "pulse from above ceiling", update_o, 1);

        // R10 prescaler write held until the next wrap
        cnt_wr = 1'b1; cnt_wdata = 16'd0; psc_wr = 1'b1; psc_wdata = 16'd1;
        edges(1);
        cnt_wr = 1'b0; psc_wr = 1'b0;
        edges(3);
        check("R10", "ratio still 1", count_o, 3);
        edges(3);
        check("R10", "wrap count", count_o, 0);
        edges(1);
        check("R10", "ratio 2 holds", count_o, 0);
        edges(1);
        check("R10", "ratio 2 steps", count_o, 1);

        // R1 reset ceiling and ratio
        cfg_enable = 1'b0; cfg_arr_preload = 1'b0; enc_a = 1'b0; enc_b = 1'b0; rst = 1'b1;
        edges(2);
        rst = 1'b0;
        check("R1", "count after second reset", count_o, 0);
        check("R1", "dir after second reset", dir_o, 0);
        cnt_wr = 1'b1; cnt_wdata = 16'hFFFE; cfg_mode = 2'd0; cfg_enable = 1'b1;
        edges(1);
        cnt_wr = 1'b0;
        edges(1);
        check("R1", "count reaches all-ones", count_o, 32'hFFFF);
        edges(1);
        check("R1", "wrap at reset ceiling", count_o, 0);
        check("R1", "pulse at reset ceiling", update_o, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule